// File: doc/BRIEF.md
# Countdown Event Timer

This block is a single down-counting event timer with a small register interface. Software first sets the run bit in a control word. It then writes a starting count to a second register. Each cycle in which the tick strobe is high and the run bit is set, the counter goes down by one. When the count runs out, a sticky pending flag is set. The interrupt output is high while that flag is set and the interrupt-enable bit is on.

The run bit gates everything. A starting count is taken only while the run bit is already set. A request to drop the pending flag is honoured only when the same control write also sets the run bit. A control write of zero halts the count and masks the interrupt line, but the pending flag is kept. Reads return the control bits and the live remaining count.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, `irq_o` is low and both the control register (offset 0x40) and the count register (offset 0x44) read as zero.
- R2: Control register at offset 0x40: bit 0 is the run bit and bit 1 is the interrupt enable, and both read back as written. Bit 4 is a write-one clear request that always reads 0. Any other offset reads zero.
- R3: A write to offset 0x44 while the stored run bit is 1 loads the count and starts the countdown. While the run bit is 0 the write is dropped and the count is unchanged.
- R4: While running, the count drops by exactly one in each cycle that `tick_en` is high and the run bit is set. It holds in cycles with `tick_en` low.
- R5: A loaded value N of 1 or more sets the pending flag on the N-th tick, and the count then stays at 0. A loaded 0 sets the flag on the first tick. After the flag is cleared, it is not set again until a new value is loaded.
- R6: `irq_o` equals the pending flag ANDed with the interrupt enable. Setting the enable later, while the flag is pending, raises `irq_o`.
- R7: A control write with bits 4 and 0 both set clears the pending flag. A write with bit 4 set and bit 0 clear leaves the flag set.
- R8: A control write of zero stops the countdown, with the count frozen, and drives `irq_o` low. The pending flag survives and shows again when the enable is restored.
- R9: A count write that lands in the same cycle as a tick takes the written value. That tick is not applied.
- R10: When the counter expires in the same cycle as an accepted clear request, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong count shows up at offset 0x44 in the cycle after the faulty edge. It also shows up as an interrupt that arrives one tick early or late, so every vector samples the line one tick before expiry and again at expiry. A pending flag that is lost or stuck shows up on `irq_o` right after a control write that toggles the enable. The gating cases are probed with writes issued while the run bit is low. The same-edge collisions are probed with a write and a tick driven in one cycle. Each of these fails within one or two cycles of the faulty edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CTRL_W   = 5;
    localparam int RUN_BIT  = 0;
    localparam int IEN_BIT  = 1;
    localparam int CLR_BIT  = 4;

    typedef struct packed {
        logic run;
        logic ien;
    } ctrl_t;

    typedef struct packed {
        logic  ctrl_wr;
        logic  value_wr;
        logic  clr_req;
        ctrl_t ctrl_new;
    } bus_cmd_t;

    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.run = w[RUN_BIT];
        c.ien = w[IEN_BIT];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w          = '0;
        w[RUN_BIT] = c.run;
        w[IEN_BIT] = c.ien;
        return w;
    endfunction

endpackage

// File: rtl/cdt_bus_decode.sv
module cdt_bus_decode
    import cdt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
    parameter logic [ADDR_W-1:0] VALUE_OFS = 8'h44
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata_lo,
    input  ctrl_t             ctrl_q,
    input  logic [CNT_W-1:0]  count_q,
    output bus_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata
);

    logic hit_ctrl;
    logic hit_value;

    assign hit_ctrl  = (addr == CTRL_OFS);
    assign hit_value = (addr == VALUE_OFS);

    always_comb begin
        cmd.ctrl_wr  = sel && wr && hit_ctrl;
        cmd.value_wr = sel && wr && hit_value;
        cmd.clr_req  = wdata_lo[CLR_BIT];
        cmd.ctrl_new = ctrl_from_word(wdata_lo);
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata = DATA_W'(ctrl_to_word(ctrl_q));
        end else if (hit_value) begin
            rdata = DATA_W'(count_q);
        end
    end

endmodule

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
    import cdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_cmd_t cmd,
    output ctrl_t    ctrl_q,
    output logic     clr_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cmd.ctrl_wr) begin
            ctrl_q <= cmd.ctrl_new;
        end
    end

    // the clear request is honoured only with the run bit in the same word
    assign clr_ok = cmd.ctrl_wr && cmd.clr_req && cmd.ctrl_new.run;

endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] count_q,
    output logic             running_q,
    output logic             pending_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic expire;

    assign step   = !load && run && running_q && tick;
    assign expire = step && (count_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
        end else if (load) begin
            count_q   <= load_val;
            running_q <= 1'b1;
        end else if (expire) begin
            count_q   <= '0;
            running_q <= 1'b0;
        end else if (step) begin
            count_q   <= count_q - ONE;
        end
    end

    // expiry wins over a clear landing on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (expire) begin
            pending_q <= 1'b1;
        end else if (clr) begin
            pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
    parameter logic [ADDR_W-1:0] VALUE_OFS = 8'h44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq_o
);

    bus_cmd_t         cmd;
    ctrl_t            ctrl_q;
    logic             clr_ok;
    logic             load_ok;
    logic [CNT_W-1:0] count_q;
    logic             running_q;
    logic             pending_q;

    cdt_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .CTRL_OFS (CTRL_OFS),
        .VALUE_OFS(VALUE_OFS)
    ) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata_lo(bus_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .count_q (count_q),
        .cmd     (cmd),
        .rdata   (bus_rdata)
    );

    cdt_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .ctrl_q(ctrl_q),
        .clr_ok(clr_ok)
    );

    // a new count is accepted only with the stored run bit set
    assign load_ok = cmd.value_wr && ctrl_q.run;

    cdt_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .load     (load_ok),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (tick_en),
        .clr      (clr_ok),
        .count_q  (count_q),
        .running_q(running_q),
        .pending_q(pending_q)
    );

    assign irq_o = pending_q && ctrl_q.ien;

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h40,
    parameter logic [ADDR_W-1:0] VALUE_OFS = 8'h44
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick_en,
    input logic              irq_o,
    input logic              run_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              running_q,
    input logic              pending_q
);

    logic wr_ctrl;
    logic wr_val;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
    assign wr_val  = bus_sel && bus_wr && (bus_addr == VALUE_OFS);

    a_r3_load_taken: assert property (@(posedge clk) disable iff (rst)
        (wr_val && run_q) |=> (count_q == $past(bus_wdata[CNT_W-1:0])));

    a_r3_load_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_val && !run_q) |=> $stable(count_q));

    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_val) |=> $stable(count_q));

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && running_q && tick_en && !wr_val && (count_q > CNT_W'(1)))
        |=> (count_q == $past(count_q) - CNT_W'(1)));

    a_r7_clear_needs_run: assert property (@(posedge clk) disable iff (rst)
        (pending_q && wr_ctrl && !bus_wdata[0]) |=> pending_q);

    a_r10_expiry_sets: assert property (@(posedge clk) disable iff (rst)
        (run_q && running_q && tick_en && !wr_val && (count_q <= CNT_W'(1)))
        |=> pending_q);

    a_r8_zero_masks: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (bus_wdata == '0)) |=> !irq_o);

endmodule

bind cdt_timer cdt_timer_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .CTRL_OFS (CTRL_OFS),
    .VALUE_OFS(VALUE_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .tick_en  (tick_en),
    .irq_o    (irq_o),
    .run_q    (ctrl_q.run),
    .count_q  (count_q),
    .running_q(running_q),
    .pending_q(pending_q)
);

// File: tb/cdt_timer_tb_top.sv
`timescale 1ns/1ps
module cdt_timer_tb_top;

    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_VAL  = 8'h44;
    localparam int NVEC = 6;
    // load value, ticks until the interrupt
    localparam logic [31:0] VEC_LOAD [NVEC] = '{32'd5, 32'd1, 32'd0, 32'd3, 32'd12, 32'd2};
    localparam int          VEC_FIRE [NVEC] = '{5, 1, 1, 3, 12, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq_o;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cdt_timer dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tick_en  (tick_en),
        .irq_o    (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            @(posedge clk); #1;
            tick_en = 1'b1;
            repeat (n) @(posedge clk);
            #1;
            tick_en = 1'b0;
        end
    endtask

    task automatic wr_with_tick(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
        rd(A_VAL, v);  chk("R1 count", v, 32'd0);

        // R2 control field readback
        wr(A_CTRL, 32'h3);  rd(A_CTRL, v); chk("R2 run+ien", v, 32'h3);
        wr(A_CTRL, 32'h13); rd(A_CTRL, v); chk("R2 clr reads 0", v, 32'h3);
        rd(8'h48, v); chk("R2 other offset", v, 32'd0);
        wr(A_CTRL, 32'h2);  rd(A_CTRL, v); chk("R2 ien only", v, 32'h2);

        // R3 load gated by stored run bit
        wr(A_VAL, 32'd77); rd(A_VAL, v); chk("R3 load dropped", v, 32'd0);
        wr(A_CTRL, 32'h1); wr(A_VAL, 32'd77); rd(A_VAL, v); chk("R3 load taken", v, 32'd77);

        // R4 per-tick decrement and hold
        repeat (3) @(posedge clk);
        #1 rd(A_VAL, v); chk("R4 hold no tick", v, 32'd77);
        tick(4); rd(A_VAL, v); chk("R4 four ticks", v, 32'd73);
        wr(A_CTRL, 32'h0); tick(3); rd(A_VAL, v); chk("R8 frozen when stopped", v, 32'd73);
        wr(A_CTRL, 32'h1); tick(1); rd(A_VAL, v); chk("R4 resume", v, 32'd72);

        // R5 vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 32'h13);
            wr(A_VAL, VEC_LOAD[i]);
            rd(A_VAL, v); chk("R3 vector load", v, VEC_LOAD[i]);
            if (VEC_FIRE[i] > 1) begin
                tick(VEC_FIRE[i] - 1);
                chk("R5 no early irq", {31'd0, irq_o}, 32'd0);
                rd(A_VAL, v); chk("R4 vector count", v, VEC_LOAD[i] - 32'(VEC_FIRE[i] - 1));
            end
            tick(1);
            chk("R5 irq at expiry", {31'd0, irq_o}, 32'd1);
            tick(2);
            rd(A_VAL, v); chk("R5 holds zero", v, 32'd0);
        end

        // R8 zero control write masks but keeps pending
        wr(A_CTRL, 32'h0);  chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
        wr(A_CTRL, 32'h3);  chk("R8 pending kept", {31'd0, irq_o}, 32'd1);

        // R7 clear needs the run bit in the same write
        wr(A_CTRL, 32'h12); chk("R7 clear ignored", {31'd0, irq_o}, 32'd1);
        wr(A_CTRL, 32'h13); chk("R7 clear taken", {31'd0, irq_o}, 32'd0);

        // R6 late enable raises the line
        wr(A_CTRL, 32'h1); wr(A_VAL, 32'd2); tick(2);
        chk("R6 masked pending", {31'd0, irq_o}, 32'd0);
        wr(A_CTRL, 32'h3);
        chk("R6 enable raises irq", {31'd0, irq_o}, 32'd1);

        // R9 load beats a coincident tick
        wr(A_CTRL, 32'h13); wr(A_VAL, 32'd10); tick(2);
        rd(A_VAL, v); chk("R9 before reload", v, 32'd8);
        wr_with_tick(A_VAL, 32'd5);
        rd(A_VAL, v); chk("R9 reload wins", v, 32'd5);
        tick(1); rd(A_VAL, v); chk("R9 continues", v, 32'd4);

        // R10 expiry beats a coincident clear
        wr(A_CTRL, 32'h13); wr(A_VAL, 32'd2); tick(1);
        chk("R10 not yet", {31'd0, irq_o}, 32'd0);
        wr_with_tick(A_CTRL, 32'h13);
        chk("R10 set wins", {31'd0, irq_o}, 32'd1);
        rd(A_VAL, v); chk("R10 count zero", v, 32'd0);

        // R5 no refire without reload
        wr(A_CTRL, 32'h13); tick(3);
        chk("R5 no refire", {31'd0, irq_o}, 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule